// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a table of VLAN entries in on-chip storage and lets a host manage that table through a small register file. Each entry holds four things: a valid flag, a 13-bit VLAN identifier, an 8-bit database number, and a 2-bit membership code plus a 2-bit port-state code for every switch port.

The host sets up an identifier register and three data words, then writes the command register with its busy bit set. Three commands are provided:
- **Load/purge** installs, replaces or removes the entry for one identifier.
- **Find-next** returns the valid entry with the next higher identifier and leaves it in the registers. Repeating the command walks the table in ascending order.
- **Flush** empties the table.

Every command sweeps all slots once, one slot per cycle. The busy bit clears by itself after a fixed, depth-proportional number of cycles.

Register addresses on `host_waddr`/`host_raddr`:

| Address | Register |
|---|---|
| 0 | command |
| 1 | identifier |
| 2, 3, 4 | data words 0, 1, 2 |
| 5 to 7 | unused, read as zero |

Top module: `vlan_tab_engine`

## Requirements
- R1: After synchronous reset, every register reads zero and the table holds no valid entry.
- R2: Writing the command register with bit 15 set starts a command. Bit 15 then reads 1 for exactly DEPTH+2 cycles and clears by itself.
- R3: While bit 15 of the command register reads 1, host writes to any register are ignored. This includes a write on the same edge at which the command completes.
- R4: Layout of the command register: bit 15 busy, bits 14:12 opcode, bit 7 full flag, other unused bits read 0. Layout of the identifier register: bits 11:0 identifier bits 11:0, bit 12 identifier bit 12, bit 15 valid, other bits read 0. A command-register write with bit 15 clear only updates the opcode and database fields.
- R5: Load/purge (opcode 3'b011) with the valid bit set stores the entry for that identifier. Reloading an existing identifier overwrites it and uses no new slot.
- R6: Load/purge with the valid bit clear removes the entry for that identifier, if one is present.
- R7: Find-next (opcode 3'b100) selects the valid entry with the smallest identifier strictly above the identifier register. It writes that identifier with valid set, its data words and its database number into the registers.
- R8: Issuing find-next again without rewriting the identifier register continues the walk in ascending order.
- R9: When no higher valid entry exists, find-next clears only the valid bit. The identifier bits and the data words are unchanged.
- R10: Port i uses data word i/4. Its membership code is at bit (i mod 4)*4 and its state code at that bit plus 2. Field bits of ports at or above PORTS read 0.
- R11: The database number is written and read through command bits 3:0 (low nibble) and bits 11:8 (high nibble). It is stored on load and returned by find-next.
- R12: Flush (opcode 3'b001) invalidates all entries and clears the full flag.
- R13: A load of a new identifier into a table with no free slot is dropped and sets the sticky full flag. A load that overwrites an existing identifier still succeeds in that state.
- R14: Any other opcode leaves the table unchanged and takes the same DEPTH+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_waddr | input | 3 | Write register address |
| host_wdata | input | 16 | Write data |
| host_raddr | input | 3 | Read register address |
| host_rdata | output | 16 | Registered read data: contents of `host_raddr` as of the previous edge |

## Verification
Two things can land on one edge: a host register write, and the completion of a command, which rewrites the identifier, data and command registers. The bench provokes this by counting cycles from the start of a command and placing a write to the identifier register exactly on the completion edge. It then writes again one cycle later. A behavioural model predicts the first write lost and the second kept. The register rotation read back every cycle is compared with the model, so a design that lets the late write through, or drops the early one, shows up as a mismatch on the next read of that register.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int WORD_W   = 16;
  localparam int NWORDS   = 3;
  localparam int DB_W     = 8;
  localparam int VID_W    = 13;
  localparam int FIELD_W  = 4;
  localparam int PER_WORD = 4;

  localparam logic [2:0] OP_FLUSH = 3'b001;
  localparam logic [2:0] OP_LOAD  = 3'b011;
  localparam logic [2:0] OP_NEXT  = 3'b100;

  localparam logic [2:0] A_CMD = 3'd0;
  localparam logic [2:0] A_VID = 3'd1;
  localparam logic [2:0] A_W0  = 3'd2;
  localparam logic [2:0] A_W1  = 3'd3;
  localparam logic [2:0] A_W2  = 3'd4;

  // bits of data word w that belong to ports below the port count
  function automatic logic [WORD_W-1:0] word_mask(input int ports, input int w);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int f = 0; f < PER_WORD; f++)
      if (w * PER_WORD + f < ports) m[f*FIELD_W +: FIELD_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/vtab_keys.sv
module vtab_keys #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [12:0]      rd_vid,
  output logic             rd_ok,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [12:0]      set_vid,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             flush
);
  logic [DEPTH-1:0] live_q;
  logic [12:0]      vid_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
      for (int s = 0; s < DEPTH; s++) vid_q[s] <= '0;
    end else if (flush) begin
      live_q <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (set_en && set_idx == IDX_W'(s)) begin
          live_q[s] <= 1'b1;
          vid_q[s]  <= set_vid;
        end else if (clr_en && clr_idx == IDX_W'(s)) begin
          live_q[s] <= 1'b0;
        end
      end
    end
  end

  assign rd_vid = vid_q[rd_idx];
  assign rd_ok  = live_q[rd_idx];
endmodule

// File: rtl/vtab_store.sv
module vtab_store #(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int W     = 56
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/vtab_ctrl.sv
module vtab_ctrl
  import vtab_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [12:0]      key,
  input  logic             key_live,
  output logic [IDX_W-1:0] scan_idx,
  input  logic [12:0]      slot_vid,
  input  logic             slot_ok,
  output logic             set_en,
  output logic [IDX_W-1:0] set_idx,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             flush,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_waddr,
  output logic             mem_re,
  output logic [IDX_W-1:0] mem_raddr,
  output logic             fin,
  output logic             next_ok,
  output logic [12:0]      next_vid,
  output logic             dropped
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_APPLY, ST_DONE} st_e;
  st_e st_q;

  logic [IDX_W-1:0] idx_q, hit_idx_q, free_idx_q, best_idx_q;
  logic             hit_q, free_q, best_q, drop_q;
  logic [12:0]      best_vid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      hit_idx_q  <= '0;
      free_idx_q <= '0;
      best_idx_q <= '0;
      hit_q      <= 1'b0;
      free_q     <= 1'b0;
      best_q     <= 1'b0;
      drop_q     <= 1'b0;
      best_vid_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_SCAN;
          idx_q  <= '0;
          hit_q  <= 1'b0;
          free_q <= 1'b0;
          best_q <= 1'b0;
          drop_q <= 1'b0;
        end
        ST_SCAN: begin
          if (slot_ok && slot_vid == key) begin
            hit_q     <= 1'b1;
            hit_idx_q <= idx_q;
          end
          if (!slot_ok && !free_q) begin
            free_q     <= 1'b1;
            free_idx_q <= idx_q;
          end
          if (slot_ok && slot_vid > key && (!best_q || slot_vid < best_vid_q)) begin
            best_q     <= 1'b1;
            best_idx_q <= idx_q;
            best_vid_q <= slot_vid;
          end
          if (idx_q == LAST) st_q <= ST_APPLY;
          else idx_q <= idx_q + 1'b1;
        end
        ST_APPLY: begin
          st_q <= ST_DONE;
          if (op == OP_LOAD && key_live && !hit_q && !free_q) drop_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic apply_load;
  assign apply_load = (st_q == ST_APPLY) && (op == OP_LOAD);

  assign scan_idx  = idx_q;
  assign set_en    = apply_load && key_live && !hit_q && free_q;
  assign set_idx   = free_idx_q;
  assign clr_en    = apply_load && !key_live && hit_q;
  assign clr_idx   = hit_idx_q;
  assign flush     = (st_q == ST_APPLY) && (op == OP_FLUSH);
  assign mem_we    = apply_load && key_live && (hit_q || free_q);
  assign mem_waddr = hit_q ? hit_idx_q : free_idx_q;
  assign mem_re    = (st_q == ST_APPLY) && (op == OP_NEXT);
  assign mem_raddr = best_idx_q;
  assign fin       = (st_q == ST_DONE);
  assign next_ok   = best_q;
  assign next_vid  = best_vid_q;
  assign dropped   = drop_q;
endmodule

// File: rtl/vlan_tab_engine.sv
module vlan_tab_engine
  import vtab_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PORTS = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_we,
  input  logic [2:0]  host_waddr,
  input  logic [15:0] host_wdata,
  input  logic [2:0]  host_raddr,
  output logic [15:0] host_rdata
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PAY_W = DB_W + PORTS * FIELD_W;

  logic              busy_q, full_q, vid_live_q, vid_pg_q;
  logic [2:0]        op_q;
  logic [DB_W-1:0]   db_q;
  logic [11:0]       vid_lo_q;
  logic [WORD_W-1:0] word_q  [NWORDS];
  logic [WORD_W-1:0] word_rd [NWORDS];

  logic             start, fin, next_ok, dropped;
  logic [12:0]      next_vid, slot_vid, set_vid;
  logic             slot_ok, set_en, clr_en, flush, mem_we, mem_re;
  logic [IDX_W-1:0] scan_idx, set_idx, clr_idx, mem_waddr, mem_raddr;
  logic [PAY_W-1:0] pay_in, pay_out;

  assign start   = !busy_q && host_we && host_waddr == A_CMD && host_wdata[15];
  assign set_vid = {vid_pg_q, vid_lo_q};

  // pack per-port fields of the data words into the stored payload
  assign pay_in[DB_W-1:0] = db_q;
  for (genvar p = 0; p < PORTS; p++) begin : g_pack
    assign pay_in[DB_W + FIELD_W*p +: FIELD_W] =
      word_q[p / PER_WORD][(p % PER_WORD) * FIELD_W +: FIELD_W];
  end

  always_comb begin
    for (int w = 0; w < NWORDS; w++) word_rd[w] = '0;
    for (int p = 0; p < PORTS; p++)
      word_rd[p / PER_WORD][(p % PER_WORD) * FIELD_W +: FIELD_W] =
        pay_out[DB_W + FIELD_W*p +: FIELD_W];
  end

  vtab_keys #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_keys (
    .clk(clk), .rst(rst),
    .rd_idx(scan_idx), .rd_vid(slot_vid), .rd_ok(slot_ok),
    .set_en(set_en), .set_idx(set_idx), .set_vid(set_vid),
    .clr_en(clr_en), .clr_idx(clr_idx), .flush(flush)
  );

  vtab_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .W(PAY_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(pay_in),
    .re(mem_re), .raddr(mem_raddr), .rdata(pay_out)
  );

  vtab_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .op(op_q),
    .key(set_vid), .key_live(vid_live_q),
    .scan_idx(scan_idx), .slot_vid(slot_vid), .slot_ok(slot_ok),
    .set_en(set_en), .set_idx(set_idx), .clr_en(clr_en), .clr_idx(clr_idx),
    .flush(flush), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .fin(fin),
    .next_ok(next_ok), .next_vid(next_vid), .dropped(dropped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      full_q     <= 1'b0;
      op_q       <= '0;
      db_q       <= '0;
      vid_live_q <= 1'b0;
      vid_pg_q   <= 1'b0;
      vid_lo_q   <= '0;
      for (int w = 0; w < NWORDS; w++) word_q[w] <= '0;
    end else if (busy_q) begin
      if (fin) begin
        busy_q <= 1'b0;
        case (op_q)
          OP_LOAD:  if (dropped) full_q <= 1'b1;
          OP_FLUSH: full_q <= 1'b0;
          OP_NEXT: begin
            if (next_ok) begin
              {vid_pg_q, vid_lo_q} <= next_vid;
              vid_live_q <= 1'b1;
              db_q       <= pay_out[DB_W-1:0];
              for (int w = 0; w < NWORDS; w++) word_q[w] <= word_rd[w];
            end else begin
              vid_live_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end else if (host_we) begin
      case (host_waddr)
        A_CMD: begin
          busy_q <= host_wdata[15];
          op_q   <= host_wdata[14:12];
          db_q   <= {host_wdata[11:8], host_wdata[3:0]};
        end
        A_VID: begin
          vid_live_q <= host_wdata[15];
          vid_pg_q   <= host_wdata[12];
          vid_lo_q   <= host_wdata[11:0];
        end
        A_W0: word_q[0] <= host_wdata & word_mask(PORTS, 0);
        A_W1: word_q[1] <= host_wdata & word_mask(PORTS, 1);
        A_W2: word_q[2] <= host_wdata & word_mask(PORTS, 2);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else begin
      case (host_raddr)
        A_CMD:   host_rdata <= {busy_q, op_q, db_q[7:4], full_q, 3'b000, db_q[3:0]};
        A_VID:   host_rdata <= {vid_live_q, 2'b00, vid_pg_q, vid_lo_q};
        A_W0:    host_rdata <= word_q[0];
        A_W1:    host_rdata <= word_q[1];
        A_W2:    host_rdata <= word_q[2];
        default: host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/vtab_chk.sv
module vtab_chk
  import vtab_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             fin,
  input logic [2:0]       op,
  input logic [13:0]      vid_reg,
  input logic [DEPTH-1:0] live_vec,
  input logic             mem_we,
  input logic             full
);
  localparam int LAT = DEPTH + 2;

  int cnt;
  always_ff @(posedge clk) begin
    if (rst) cnt <= 0;
    else cnt <= busy ? cnt + 1 : 0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt < LAT);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(cnt) == LAT - 1);

  // R3
  vid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin) |=> $stable(vid_reg));

  // R3
  mem_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we);

  // R12
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && op == OP_FLUSH) |-> live_vec == '0);

  // R13
  full_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> $past(fin && op == OP_LOAD));
endmodule

bind vlan_tab_engine vtab_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_q), .fin(fin), .op(op_q),
  .vid_reg({vid_live_q, vid_pg_q, vid_lo_q}), .live_vec(u_keys.live_q),
  .mem_we(mem_we), .full(full_q)
);

// File: tb/test_vlan_tab_engine.sv
module test_vlan_tab_engine;
  localparam int DEPTH = 8;
  localparam int PORTS = 10;
  localparam int LAT   = DEPTH + 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_waddr = '0;
  logic [15:0] host_wdata = '0;
  logic [2:0]  host_raddr = '0;
  logic [15:0] host_rdata;

  always #5 clk = ~clk;

  vlan_tab_engine #(.DEPTH(DEPTH), .PORTS(PORTS)) i_vlan_tab_engine (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string req = "R1";

  // behavioural model state
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  logic [2:0]  m_op = '0;
  logic [7:0]  m_db = '0;
  logic        m_full = 1'b0;
  logic        m_live = 1'b0;
  logic [12:0] m_vid = '0;
  logic [15:0] m_word [3] = '{16'h0, 16'h0, 16'h0};
  logic [55:0] m_tab [int];
  int          rsel = 0;

  function automatic logic [15:0] mask_of(int w);
    logic [15:0] m = '0;
    for (int f = 0; f < 4; f++) if (w * 4 + f < PORTS) m[f*4 +: 4] = 4'hF;
    return m;
  endfunction

  function automatic logic [15:0] view(int a);
    case (a)
      0: return {m_busy, m_op, m_db[7:4], m_full, 3'b000, m_db[3:0]};
      1: return {m_live, 2'b00, m_vid};
      2, 3, 4: return m_word[a-2];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic execute();
    int key = int'(m_vid);
    int best = -1;
    case (m_op)
      3'b011: begin
        if (m_live) begin
          if (m_tab.exists(key) || m_tab.num() < DEPTH)
            m_tab[key] = {m_db, m_word[2], m_word[1], m_word[0]};
          else m_full = 1'b1;
        end else if (m_tab.exists(key)) m_tab.delete(key);
      end
      3'b001: begin m_tab.delete(); m_full = 1'b0; end
      3'b100: begin
        foreach (m_tab[k]) if (k > key && (best < 0 || k < best)) best = k;
        if (best >= 0) begin
          m_vid  = 13'(best);
          m_live = 1'b1;
          {m_db, m_word[2], m_word[1], m_word[0]} = m_tab[best];
        end else m_live = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic model_edge(input logic we, input logic [2:0] a, input logic [15:0] wd);
    if (m_busy) begin
      m_cnt--;
      if (m_cnt == 0) begin execute(); m_busy = 1'b0; end
    end else if (we) begin
      case (a)
        3'd0: begin
          m_busy = wd[15]; m_op = wd[14:12]; m_db = {wd[11:8], wd[3:0]};
          if (wd[15]) m_cnt = LAT;
        end
        3'd1: begin m_live = wd[15]; m_vid = wd[12:0]; end
        3'd2, 3'd3, 3'd4: m_word[a-2] = wd & mask_of(int'(a) - 2);
        default: ;
      endcase
    end
  endtask

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input int a);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: reg %0d actual %h expected %h at %0t", req, a, got, exp, $time);
    end
  endtask

  // one clock: drive, advance model, sample at the falling edge
  task automatic step(input logic we, input logic [2:0] a, input logic [15:0] wd);
    logic [15:0] exp;
    int ra = rsel;
    host_we = we; host_waddr = a; host_wdata = wd; host_raddr = 3'(ra);
    exp = view(ra);
    model_edge(we, a, wd);
    rsel = (rsel + 1) % 6;
    @(posedge clk);
    @(negedge clk);
    check(host_rdata, exp, ra);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step(1'b1, a, d);
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] db);
    wr(3'd0, {1'b1, op, db[7:4], 4'b0000, db[3:0]});
    while (m_busy) idle(1);
    idle(6);
  endtask

  task automatic set_vid(input logic live, input logic [12:0] v);
    wr(3'd1, {live, 2'b00, v});
  endtask

  task automatic load(input logic [12:0] v, input logic [7:0] db,
                      input logic [15:0] w0, input logic [15:0] w1, input logic [15:0] w2);
    wr(3'd2, w0); wr(3'd3, w1); wr(3'd4, w2);
    set_vid(1'b1, v);
    run(3'b011, db);
  endtask

  task automatic walk();
    set_vid(1'b0, 13'h0);
    for (int i = 0; i <= DEPTH; i++) begin
      run(3'b100, 8'h00);
      if (!m_live) break;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL %s: watchdog actual still running expected finished", req);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = "R1";
    check(host_rdata, 16'h0000, 0);
    rst = 1'b0;
    idle(8);
    walk();                                   // R1: empty table

    req = "R4";
    wr(3'd1, 16'hFFFF); idle(6);
    wr(3'd0, 16'h7FFF); idle(6);              // no start, fields only

    req = "R10";
    wr(3'd2, 16'hFFFF); wr(3'd3, 16'hFFFF); wr(3'd4, 16'hFFFF); idle(6);

    req = "R5";
    load(13'd100,  8'h3C, 16'h1234, 16'h5678, 16'h009A);
    load(13'd5000, 8'hA5, 16'hBEEF, 16'h0F0F, 16'h00F0);
    load(13'd7,    8'h01, 16'h1111, 16'h2222, 16'h0033);
    load(13'd100,  8'hC3, 16'hAAAA, 16'h5555, 16'h00FF); // overwrite

    req = "R2";
    idle(3);

    req = "R7";
    walk();

    req = "R8";
    set_vid(1'b1, 13'd7);                     // equal key, strictly above
    run(3'b100, 8'h00);
    run(3'b100, 8'h00);

    req = "R9";
    run(3'b100, 8'h00);
    run(3'b100, 8'h00);

    req = "R11";
    load(13'h1FFF, 8'hF0, 16'h0001, 16'h0002, 16'h0003);
    set_vid(1'b0, 13'd5000);
    run(3'b100, 8'h5A);

    req = "R6";
    set_vid(1'b0, 13'd100);
    run(3'b011, 8'h00);
    set_vid(1'b0, 13'd101);                   // absent entry
    run(3'b011, 8'h00);
    walk();

    req = "R3";
    set_vid(1'b1, 13'h0AA);
    wr(3'd0, 16'hB011);                       // start load
    wr(3'd1, 16'h8123);
    wr(3'd2, 16'h5555);
    wr(3'd0, 16'h9000);
    idle(LAT - 4);
    wr(3'd1, 16'h8042);                       // lands on the completion edge
    wr(3'd1, 16'h8043);                       // accepted
    idle(8);
    walk();

    req = "R14";
    run(3'b111, 8'h77);
    run(3'b000, 8'h00);
    run(3'b010, 8'h12);
    walk();

    req = "R12";
    run(3'b001, 8'h00);
    walk();

    req = "R13";
    for (int i = 0; i < DEPTH; i++)
      load(13'(10 + i), 8'(i), 16'(i * 3), 16'(i * 5), 16'(i * 7));
    load(13'd200, 8'h99, 16'hDEAD, 16'hBEEF, 16'h00AA);   // dropped
    load(13'd12,  8'h44, 16'h4444, 16'h4444, 16'h0044);   // overwrite ok
    set_vid(1'b0, 13'd15);
    run(3'b011, 8'h00);
    load(13'd300, 8'h30, 16'h3030, 16'h0303, 16'h0030);
    walk();

    req = "R12";
    run(3'b001, 8'h00);
    walk();
    idle(6);

    summary();
    $finish;
  end
endmodule